// File: doc/BRIEF.md
# Shift Unit with Status Flags

This block shifts a 32-bit operand left logically, right logically or right arithmetically, and works out the next value of a six-bit status flag word holding carry, parity, auxiliary carry, zero, sign and overflow. The caller presents the operand, a raw shift count, an operation code and the current flags with a valid strobe. One clock later the block returns the shifted value and the updated flags.

The flag rules depend on the shift amount. An effective count of zero leaves every flag and the operand untouched. Carry takes the last bit pushed out of the operand. Overflow has a defined meaning only for a one-bit shift and is cleared for longer shifts. Sign, zero and parity follow the result. Auxiliary carry has no defined meaning for a shift, so it is cleared whenever the shift does anything. Only the low five bits of the count are used.

Top module: `shift_flag_unit`

## Requirements
- R1: Operation code 2'b00 shifts left logically: vacated low bits are filled with zeros.
- R2: Operation code 2'b01 shifts right logically: vacated high bits are filled with zeros.
- R3: Operation code 2'b10 shifts right arithmetically: vacated high bits copy the operand's MSB, so all ones shifted by any non-zero amount stays all ones with the sign flag set.
- R4: The effective shift amount is the count modulo 32 (its low five bits). A count of 32 acts as zero and a count of 33 acts as one.
- R5: For a non-zero effective amount, the carry flag (flags bit 0) equals the last operand bit shifted out.
- R6: For an effective amount of zero, the result equals the operand and all six flags equal flags_in.
- R7: For an effective amount of one, the overflow flag (flags bit 5) is result MSB XOR carry for a left shift, the original operand MSB for a logical right shift, and 0 for an arithmetic right shift.
- R8: For an effective amount of two or more, the overflow flag is 0.
- R9: For a non-zero effective amount, the sign flag (bit 4) is the result MSB, the zero flag (bit 3) is set when the result is zero, and the parity flag (bit 1) is set when the result's low byte has an even number of one bits.
- R10: For a non-zero effective amount, the auxiliary carry flag (bit 2) is 0.
- R11: Operation code 2'b11 performs no shift: the result equals the operand and the flags equal flags_in, whatever the count.
- R12: Outputs are registered: result and flags_out appear on the clock edge that samples in_valid high, with out_valid high for that one cycle. Synchronous reset clears out_valid, result and flags_out to zero; when in_valid is low the result and flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| operand | input | 32 | Value to shift |
| count | input | 8 | Raw shift count; low five bits used |
| op_sel | input | 2 | Operation code |
| flags_in | input | 6 | Current flags {OF,SF,ZF,AF,PF,CF} |
| out_valid | output | 1 | Result and flags are new this cycle |
| result | output | 32 | Shifted value |
| flags_out | output | 6 | Next flags {OF,SF,ZF,AF,PF,CF} |

## Verification
Every output register is loaded from one clock edge of combinational logic, so a fault in the barrel stages or the flag logic shows at the ports one cycle after the request that triggers it, and never later. A wrong stage or wrong fill bit appears as a corrupted result for some count whose binary form selects that stage, which is why every amount from 0 to 31 is applied for each operation with random operands. A fault in the hold path for zero counts shows as a flag changing when the incoming flags are random and the count is a multiple of 32.

// File: rtl/shf_pkg.sv
`timescale 1ns/1ps
package shf_pkg;
  typedef enum logic [1:0] {
    SH_LL   = 2'b00,
    SH_LR   = 2'b01,
    SH_AR   = 2'b10,
    SH_PASS = 2'b11
  } shf_op_e;

  localparam int NFLAGS = 6;
  localparam int FL_CF  = 0;
  localparam int FL_PF  = 1;
  localparam int FL_AF  = 2;
  localparam int FL_ZF  = 3;
  localparam int FL_SF  = 4;
  localparam int FL_OF  = 5;
endpackage

// File: rtl/shf_barrel.sv
`timescale 1ns/1ps
module shf_barrel
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [SH_W-1:0]   amt,
  input  shf_op_e           op,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  // Each stage vector carries one guard bit that collects the bit shifted out.
  logic [DATA_W:0] rs [0:SH_W];
  logic [DATA_W:0] ls [0:SH_W];
  logic            fill;

  assign fill  = (op == SH_AR) ? a[DATA_W-1] : 1'b0;
  assign rs[0] = {a, 1'b0};
  assign ls[0] = {1'b0, a};

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int S = 1 << k;
    assign rs[k+1] = amt[k] ? {{S{fill}}, rs[k][DATA_W:S]} : rs[k];
    assign ls[k+1] = amt[k] ? {ls[k][DATA_W-S:0], {S{1'b0}}} : ls[k];
  end

  always_comb begin
    unique case (op)
      SH_LL: begin
        res  = ls[SH_W][DATA_W-1:0];
        cout = ls[SH_W][DATA_W];
      end
      SH_LR, SH_AR: begin
        res  = rs[SH_W][DATA_W:1];
        cout = rs[SH_W][0];
      end
      default: begin
        res  = a;
        cout = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/shf_flag_gen.sv
`timescale 1ns/1ps
module shf_flag_gen
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] res,
  input  logic              cout,
  input  logic              a_msb,
  input  logic [SH_W-1:0]   amt,
  input  shf_op_e           op,
  input  logic [NFLAGS-1:0] flags_in,
  output logic [NFLAGS-1:0] flags_next
);
  logic amt_zero;
  logic amt_one;
  logic of_one;

  assign amt_zero = (amt == '0);
  assign amt_one  = (amt == SH_W'(1));

  always_comb begin
    unique case (op)
      SH_LL:   of_one = res[DATA_W-1] ^ cout;
      SH_LR:   of_one = a_msb;
      default: of_one = 1'b0;
    endcase
  end

  always_comb begin
    flags_next = flags_in;
    if (op != SH_PASS && !amt_zero) begin
      flags_next[FL_CF] = cout;
      flags_next[FL_PF] = ~^res[7:0];
      flags_next[FL_AF] = 1'b0;
      flags_next[FL_ZF] = (res == '0);
      flags_next[FL_SF] = res[DATA_W-1];
      flags_next[FL_OF] = amt_one ? of_one : 1'b0;
    end
  end
endmodule

// File: rtl/shift_flag_unit.sv
`timescale 1ns/1ps
module shift_flag_unit
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  count,
  input  logic [1:0]        op_sel,
  input  logic [5:0]        flags_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [5:0]        flags_out
);
  localparam int SH_W = $clog2(DATA_W);

  shf_op_e           op;
  logic [SH_W-1:0]   amt;
  logic [DATA_W-1:0] sh_res;
  logic              sh_cout;
  logic [NFLAGS-1:0] fl_next;

  assign op  = shf_op_e'(op_sel);
  assign amt = count[SH_W-1:0];

  shf_barrel #(.DATA_W(DATA_W), .SH_W(SH_W)) u_barrel (
    .a    (operand),
    .amt  (amt),
    .op   (op),
    .res  (sh_res),
    .cout (sh_cout)
  );

  shf_flag_gen #(.DATA_W(DATA_W), .SH_W(SH_W)) u_flags (
    .res        (sh_res),
    .cout       (sh_cout),
    .a_msb      (operand[DATA_W-1]),
    .amt        (amt),
    .op         (op),
    .flags_in   (flags_in),
    .flags_next (fl_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= sh_res;
        flags_out <= fl_next;
      end
    end
  end

  // R6
  count_zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && amt == '0) |=> (result == $past(operand) && flags_out == $past(flags_in)));

  // R11
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b11) |=> (result == $past(operand) && flags_out == $past(flags_in)));

  // R10
  aux_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && amt != '0 && op_sel != 2'b11) |=> !flags_out[FL_AF]);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && amt > SH_W'(1) && op_sel != 2'b11) |=> !flags_out[FL_OF]);

  // R3
  sar_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b10 && operand == '1 && amt != '0)
      |=> (result == '1 && flags_out[FL_SF]));

  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flags_out)));

  // R9
  zero_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && amt != '0 && op_sel != 2'b11)
      |=> (flags_out[FL_ZF] == (result == '0) && flags_out[FL_SF] == result[DATA_W-1]));
endmodule

// File: tb/shift_flag_unit_bench.sv
`timescale 1ns/1ps
module shift_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [7:0]  count = '0;
  logic [1:0]  op_sel = '0;
  logic [5:0]  flags_in = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [5:0]  flags_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  shift_flag_unit u_shift_flag_unit (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .operand   (operand),
    .count     (count),
    .op_sel    (op_sel),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .flags_out (flags_out)
  );

  // Reference: one bit per step; flags {OF,SF,ZF,AF,PF,CF}.
  function automatic logic [37:0] ref_calc(input logic [1:0] op, input logic [31:0] a,
                                           input logic [7:0] c, input logic [5:0] fin);
    int n;
    logic [31:0] v;
    logic cy;
    logic [5:0] f;
    n  = int'(c[4:0]);
    v  = a;
    cy = 1'b0;
    f  = fin;
    if (op == 2'b11 || n == 0) return {fin, a};
    for (int i = 0; i < n; i++) begin
      case (op)
        2'b00:   begin cy = v[31]; v = {v[30:0], 1'b0}; end
        2'b01:   begin cy = v[0];  v = {1'b0, v[31:1]}; end
        default: begin cy = v[0];  v = {v[31], v[31:1]}; end
      endcase
    end
    f[0] = cy;
    f[1] = ~^v[7:0];
    f[2] = 1'b0;
    f[3] = (v == 32'd0);
    f[4] = v[31];
    if (n == 1) f[5] = (op == 2'b00) ? (v[31] ^ cy) : (op == 2'b01) ? a[31] : 1'b0;
    else        f[5] = 1'b0;
    return {f, v};
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [7:0] c,
                        input logic [5:0] fin, input string tag);
    logic [37:0] exp;
    @(negedge clk);
    in_valid = 1'b1;
    op_sel   = op;
    operand  = a;
    count    = c;
    flags_in = fin;
    exp = ref_calc(op, a, c, fin);
    @(negedge clk);
    in_valid = 1'b0;
    n_checks++;
    if (out_valid !== 1'b1 || result !== exp[31:0] || flags_out !== exp[37:32]) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h cnt=%0d: actual v=%b res=%h fl=%b expected v=1 res=%h fl=%b",
               tag, op, a, c, out_valid, result, flags_out, exp[31:0], exp[37:32]);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held_res;
    logic [5:0]  held_fl;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    n_checks++;
    if (out_valid !== 1'b0 || result !== 32'd0 || flags_out !== 6'd0) begin
      n_fail++;
      $display("FAIL R12 reset: actual v=%b res=%h fl=%b expected 0/0/0", out_valid, result, flags_out);
    end

    // R3 all ones arithmetic right
    run_op(2'b10, 32'hFFFF_FFFF, 8'd1, 6'b000000, "R3 ones by 1");
    run_op(2'b10, 32'hFFFF_FFFF, 8'd31, 6'b101100, "R3 ones by 31");
    run_op(2'b10, 32'h8000_0000, 8'd4, 6'b000000, "R3 sign fill");
    // R1, R7 left by one overflow
    run_op(2'b00, 32'h8000_0000, 8'd1, 6'b000000, "R1 R7 R5 left msb out");
    run_op(2'b00, 32'h4000_0000, 8'd1, 6'b000000, "R7 left into msb");
    run_op(2'b00, 32'h0000_0001, 8'd31, 6'b111111, "R1 R8 left 31");
    // R2, R7 logical right
    run_op(2'b01, 32'h8000_0000, 8'd1, 6'b000000, "R2 R7 right msb");
    run_op(2'b01, 32'h0000_0001, 8'd1, 6'b000000, "R2 R5 R9 right to zero");
    // R4 count masking
    run_op(2'b00, 32'h1234_5678, 8'd32, 6'b101010, "R4 R6 count 32");
    run_op(2'b01, 32'h8765_4321, 8'd33, 6'b010101, "R4 count 33");
    run_op(2'b10, 32'hF0F0_0F0F, 8'd224, 6'b110011, "R4 count 224");
    // R6 zero count
    run_op(2'b10, 32'hDEAD_BEEF, 8'd0, 6'b111111, "R6 zero count");
    // R11 pass code
    run_op(2'b11, 32'hCAFE_F00D, 8'd5, 6'b100101, "R11 pass");
    // R9 parity low byte
    run_op(2'b01, 32'h0000_0300, 8'd8, 6'b000000, "R9 parity even");
    run_op(2'b01, 32'h0000_0200, 8'd8, 6'b000010, "R9 parity odd");
    // R10 aux cleared
    run_op(2'b00, 32'h0000_00FF, 8'd3, 6'b000100, "R10 aux");

    // R12 idle hold
    held_res = result;
    held_fl  = flags_out;
    @(negedge clk);
    operand = 32'h5555_5555;
    count   = 8'd7;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || result !== held_res || flags_out !== held_fl) begin
      n_fail++;
      $display("FAIL R12 idle: actual v=%b res=%h fl=%b expected 0 res=%h fl=%b",
               out_valid, result, flags_out, held_res, held_fl);
    end

    // R1 R2 R3 R5 R7 R8 R9 sweep over every amount with random data
    for (int op = 0; op < 3; op++) begin
      for (int c = 0; c < 32; c++) begin
        for (int r = 0; r < 4; r++) begin
          run_op(2'(op), $urandom(), 8'(c + 32 * ($urandom() % 8)), 6'($urandom()), "R5 R9 sweep");
        end
      end
    end
    // random including pass code
    for (int i = 0; i < 200; i++) begin
      run_op(2'($urandom()), $urandom(), 8'($urandom()), 6'($urandom()), "R11 R6 random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule